// File: doc/BRIEF.md
# DS3 C-bit Parity Overhead Generator

This block sits in the transmit path of a DS3 framer that uses the C-bit parity format. A serial stream enters one bit per clock, and a start-of-frame strobe marks the first bit of each M-frame. The block follows the bit position with a small state machine. At every overhead position it overwrites the bit with the value the format calls for: the X-bits, P-bits, M-bits, F-bits and all 21 C-bits. Payload bits pass through untouched. The framed stream leaves one clock later, with its own start-of-frame marker.

The parity of all payload bits in an M-frame is kept and placed in the next frame. It goes into both P-bits and into the three C-bits of the third subframe. The three C-bits of the fourth subframe carry a far-end block error (FEBE) flag. That flag comes either from C-bit parity errors reported during the previous frame or from a programmed value. The two X-bits carry a remote alarm indication. Each of its four causes (loss of signal, severely errored frame, loss of frame, AIS) can be masked. The FEAC bit and the three path data-link bits are taken from serial inputs, and a take strobe tells each source when its bit is used.

With frame generation off, the stream passes through unchanged. P-bit generation can still be switched on by itself in that case.

The position tracker has three states:
- `ST_WAIT` (not yet aligned)
- `ST_OH` (the current bit is an overhead bit)
- `ST_PAY` (the current bit is a payload bit)

Its transitions are:
- `WAIT→OH` on the first start strobe.
- `OH→PAY` always.
- `PAY→PAY` inside a block.
- `PAY→OH` after the 84th payload bit.
- A start strobe in any state forces `OH` at the frame origin (resync).

Top module: `ds3_cbit_ohgen`

## Requirements
- R1: With frame generation on, both P-bits (block 0 of subframes 3 and 4) carry the modulo-2 sum of all payload bits of the previous M-frame. Before any frame has completed, that sum reads 0.
- R2: With frame generation off and P-bit generation on, only the P-bits are replaced by the previous frame's payload parity. Every other bit passes through.
- R3: With frame generation on, the C-bits of subframes 2, 6 and 7, and the first two C-bits of subframe 1, are driven to 1.
- R4: With frame generation on, the third C-bit of subframe 1 carries `feac_bit`, and `feac_take` is high in exactly that input cycle. The three C-bits of subframe 5 carry `dl_bit`, and `dl_take` is high in each of those input cycles.
- R5: With frame generation on, the three C-bits of subframe 3 carry the previous frame's payload parity.
- R6: With frame generation on, the three C-bits of subframe 4 carry FEBE. When `febe_auto`=1, FEBE is 0 if `cp_err` was high in any cycle of the previous aligned frame, and 1 otherwise. When `febe_auto`=0, FEBE equals `febe_val`.
- R7: With frame generation on, X1 and X2 (block 0 of subframes 1 and 2) are 0 when any enabled alarm cause is high, and 1 otherwise. The enable bits are `rai_en[0]`=LOS, `[1]`=SEF, `[2]`=LOF and `[3]`=AIS.
- R8: With frame generation on, M1/M2/M3 (block 0 of subframes 5, 6 and 7) are 0/1/0. In every subframe, F1..F4 (blocks 1, 3, 5, 7) are 1/0/0/1.
- R9: With frame generation and P-bit generation both off, `dout` equals `din` of the previous cycle for every bit.
- R10: Payload bits (84 per block, after the block's overhead bit) pass through unchanged. Before the first `sof_in`, every bit passes through. `dout_sof` is high exactly with the output bit that entered with `sof_in`.
- R11: Every output bit leaves one clock after its input bit. After reset, `dout` and `dout_sof` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial input bit |
| sof_in | input | 1 | High with the first bit (X1) of an M-frame |
| frame_gen_en | input | 1 | Overwrite all overhead bits |
| pbit_gen_en | input | 1 | Overwrite P-bits even without frame generation |
| febe_auto | input | 1 | 1: FEBE from C-bit parity errors; 0: from febe_val |
| febe_val | input | 1 | Programmed FEBE value |
| rai_en | input | 4 | Alarm cause enables: [0] LOS, [1] SEF, [2] LOF, [3] AIS |
| los | input | 1 | Loss of signal flag |
| sef | input | 1 | Severely errored frame flag |
| lof | input | 1 | Loss of frame flag |
| ais | input | 1 | AIS flag |
| cp_err | input | 1 | C-bit parity error pulse from the receive side |
| feac_bit | input | 1 | Serial FEAC source bit |
| dl_bit | input | 1 | Serial path data-link source bit |
| dout | output | 1 | Framed serial output bit |
| dout_sof | output | 1 | High with the first output bit of an M-frame |
| feac_take | output | 1 | feac_bit is consumed this cycle |
| dl_take | output | 1 | dl_bit is consumed this cycle |

## Verification
The bench targets these corner cases and the failure each one exposes:
- **Frame boundary.** The parity and the FEBE flag must switch exactly there. A design that latched one bit early or late, or cleared the sum at the wrong time, would put a stale or partial parity into the P-bits and the third subframe's C-bits.
- **P-bit generation with frame generation off.** A design that tied P-bit generation to frame generation would pass the raw bits through here.
- **Masked alarm causes.** With active causes masked, the X-bits must read 1. A design that ignored the mask would drive them to 0.
- **FEBE mode switch.** Frames with and without reported parity errors, under both automatic and programmed FEBE, expose a design that inverted the flag or ignored the mode.
- **Bits before the first start strobe.** A tracker that began counting before alignment would corrupt these.
- **Neighbouring C-bit positions.** A one-off slot decode would swap the FEAC or data-link bit with a fixed one; comparing every bit of each frame catches this.

// File: rtl/ds3_oh_pkg.sv
package ds3_oh_pkg;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_OH,
        ST_PAY
    } pos_state_e;

    typedef enum logic [3:0] {
        SL_RAW,
        SL_PAY,
        SL_X,
        SL_P,
        SL_M,
        SL_F,
        SL_CONE,
        SL_FEAC,
        SL_CPAR,
        SL_FEBE,
        SL_DL
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e kind;
        logic       fixed;
    } slot_t;

endpackage

// File: rtl/ds3_frame_pos.sv
module ds3_frame_pos
    import ds3_oh_pkg::*;
#(
    parameter int SUBFR = 7,
    parameter int BLKS  = 8,
    parameter int PAYB  = 84,
    localparam int SF_W = $clog2(SUBFR),
    localparam int BK_W = $clog2(BLKS),
    localparam int BT_W = $clog2(PAYB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof_in,
    output logic            cur_valid,
    output logic            cur_oh,
    output logic [SF_W-1:0] cur_sf,
    output logic [BK_W-1:0] cur_blk,
    output logic            frame_first,
    output logic            frame_last
);

    pos_state_e      state_q, state_d;
    logic [SF_W-1:0] sf_q;
    logic [BK_W-1:0] blk_q;
    logic [BT_W-1:0] bit_q, cur_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            sf_q    <= '0;
            blk_q   <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            sf_q    <= cur_sf;
            blk_q   <= cur_blk;
            bit_q   <= cur_bit;
        end
    end

    always_comb begin
        state_d   = state_q;
        cur_valid = 1'b0;
        cur_sf    = sf_q;
        cur_blk   = blk_q;
        cur_bit   = bit_q;
        if (sof_in) begin
            state_d   = ST_OH;
            cur_valid = 1'b1;
            cur_sf    = '0;
            cur_blk   = '0;
            cur_bit   = '0;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    state_d = ST_WAIT;
                end
                ST_OH: begin
                    cur_valid = 1'b1;
                    cur_bit   = BT_W'(1);
                    state_d   = ST_PAY;
                end
                ST_PAY: begin
                    cur_valid = 1'b1;
                    if (bit_q == BT_W'(PAYB)) begin
                        cur_bit = '0;
                        state_d = ST_OH;
                        if (blk_q == BK_W'(BLKS - 1)) begin
                            cur_blk = '0;
                            cur_sf  = (sf_q == SF_W'(SUBFR - 1)) ? '0 : sf_q + SF_W'(1);
                        end else begin
                            cur_blk = blk_q + BK_W'(1);
                        end
                    end else begin
                        cur_bit = bit_q + BT_W'(1);
                        state_d = ST_PAY;
                    end
                end
                default: begin
                    state_d = ST_WAIT;
                end
            endcase
        end
    end

    assign cur_oh      = cur_valid && (state_d == ST_OH);
    assign frame_first = cur_oh && (cur_sf == '0) && (cur_blk == '0);
    assign frame_last  = cur_valid && (cur_bit == BT_W'(PAYB))
                         && (cur_blk == BK_W'(BLKS - 1)) && (cur_sf == SF_W'(SUBFR - 1));

    // R10: a start strobe always realigns the tracker to the frame origin
    p_sof_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sof_in |=> (state_q == ST_OH) && (sf_q == '0) && (blk_q == '0) && (bit_q == '0));

    // R10: the bit counter never leaves its block range
    p_bit_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= BT_W'(PAYB));

endmodule

// File: rtl/ds3_slot_decode.sv
module ds3_slot_decode
    import ds3_oh_pkg::*;
#(
    parameter int SF_W = 3,
    parameter int BK_W = 3
) (
    input  logic            cur_valid,
    input  logic            cur_oh,
    input  logic [SF_W-1:0] cur_sf,
    input  logic [BK_W-1:0] cur_blk,
    output slot_t           slot
);

    int sf_i;
    int bk_i;

    always_comb begin
        sf_i       = int'(cur_sf);
        bk_i       = int'(cur_blk);
        slot.kind  = SL_RAW;
        slot.fixed = 1'b0;
        if (!cur_valid) begin
            slot.kind = SL_RAW;
        end else if (!cur_oh) begin
            slot.kind = SL_PAY;
        end else if (bk_i == 0) begin
            case (sf_i)
                0, 1:    slot.kind = SL_X;
                2, 3:    slot.kind = SL_P;
                default: begin
                    slot.kind  = SL_M;
                    slot.fixed = (sf_i == 5);
                end
            endcase
        end else if (cur_blk[0]) begin
            slot.kind  = SL_F;
            slot.fixed = (bk_i == 1) || (bk_i == 7);
        end else begin
            case (sf_i)
                0:       slot.kind = (bk_i == 6) ? SL_FEAC : SL_CONE;
                2:       slot.kind = SL_CPAR;
                3:       slot.kind = SL_FEBE;
                4:       slot.kind = SL_DL;
                default: slot.kind = SL_CONE;
            endcase
        end
    end

endmodule

// File: rtl/ds3_par_febe.sv
module ds3_par_febe (
    input  logic clk,
    input  logic rst_n,
    input  logic cur_valid,
    input  logic is_pay,
    input  logic frame_first,
    input  logic frame_last,
    input  logic din,
    input  logic cp_err,
    output logic par_q,
    output logic febe_err_q
);

    logic acc_q;
    logic err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q      <= 1'b0;
            err_q      <= 1'b0;
            par_q      <= 1'b0;
            febe_err_q <= 1'b0;
        end else if (frame_first) begin
            acc_q <= 1'b0;
            err_q <= cp_err;
        end else if (cur_valid) begin
            if (frame_last) begin
                par_q      <= acc_q ^ (is_pay & din);
                febe_err_q <= err_q | cp_err;
                acc_q      <= 1'b0;
                err_q      <= 1'b0;
            end else begin
                acc_q <= acc_q ^ (is_pay & din);
                err_q <= err_q | cp_err;
            end
        end
    end

    // R6: an error reported in the closing bit of a frame marks that frame
    p_febe_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && frame_last && cp_err) |=> febe_err_q);

    // R1: the stored parity only changes at a frame end
    p_par_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_valid && frame_last) |=> $stable(par_q));

endmodule

// File: rtl/ds3_cbit_ohgen.sv
module ds3_cbit_ohgen
    import ds3_oh_pkg::*;
#(
    parameter int SUBFR = 7,
    parameter int BLKS  = 8,
    parameter int PAYB  = 84,
    localparam int SF_W = $clog2(SUBFR),
    localparam int BK_W = $clog2(BLKS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic       sof_in,
    input  logic       frame_gen_en,
    input  logic       pbit_gen_en,
    input  logic       febe_auto,
    input  logic       febe_val,
    input  logic [3:0] rai_en,
    input  logic       los,
    input  logic       sef,
    input  logic       lof,
    input  logic       ais,
    input  logic       cp_err,
    input  logic       feac_bit,
    input  logic       dl_bit,
    output logic       dout,
    output logic       dout_sof,
    output logic       feac_take,
    output logic       dl_take
);

    logic            cur_valid, cur_oh, frame_first, frame_last;
    logic [SF_W-1:0] cur_sf;
    logic [BK_W-1:0] cur_blk;
    slot_t           slot;
    logic            par_q, febe_err_q;
    logic            rai_bit, febe_bit, dout_d;

    ds3_frame_pos #(
        .SUBFR (SUBFR),
        .BLKS  (BLKS),
        .PAYB  (PAYB)
    ) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_in      (sof_in),
        .cur_valid   (cur_valid),
        .cur_oh      (cur_oh),
        .cur_sf      (cur_sf),
        .cur_blk     (cur_blk),
        .frame_first (frame_first),
        .frame_last  (frame_last)
    );

    ds3_slot_decode #(
        .SF_W (SF_W),
        .BK_W (BK_W)
    ) u_dec (
        .cur_valid (cur_valid),
        .cur_oh    (cur_oh),
        .cur_sf    (cur_sf),
        .cur_blk   (cur_blk),
        .slot      (slot)
    );

    ds3_par_febe u_par (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_valid   (cur_valid),
        .is_pay      (slot.kind == SL_PAY),
        .frame_first (frame_first),
        .frame_last  (frame_last),
        .din         (din),
        .cp_err      (cp_err),
        .par_q       (par_q),
        .febe_err_q  (febe_err_q)
    );

    assign rai_bit  = ~|(rai_en & {ais, lof, sef, los});
    assign febe_bit = febe_auto ? ~febe_err_q : febe_val;

    always_comb begin
        dout_d = din;
        if (frame_gen_en) begin
            unique case (slot.kind)
                SL_RAW, SL_PAY: dout_d = din;
                SL_X:           dout_d = rai_bit;
                SL_P, SL_CPAR:  dout_d = par_q;
                SL_M, SL_F:     dout_d = slot.fixed;
                SL_CONE:        dout_d = 1'b1;
                SL_FEAC:        dout_d = feac_bit;
                SL_FEBE:        dout_d = febe_bit;
                SL_DL:          dout_d = dl_bit;
                default:        dout_d = din;
            endcase
        end else if (pbit_gen_en && (slot.kind == SL_P)) begin
            dout_d = par_q;
        end
    end

    assign feac_take = frame_gen_en && (slot.kind == SL_FEAC);
    assign dl_take   = frame_gen_en && (slot.kind == SL_DL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout     <= 1'b0;
            dout_sof <= 1'b0;
        end else begin
            dout     <= dout_d;
            dout_sof <= frame_first;
        end
    end

    // R1 / R2: P-bit slots carry the stored parity whenever either enable is set
    p_pbit_par_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot.kind == SL_P) && (frame_gen_en || pbit_gen_en)) |=> (dout == $past(par_q)));

    // R9: with both enables off the stream is a one-cycle delay of the input
    p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_gen_en && !pbit_gen_en) |=> (dout == $past(din)));

    // R10: payload bits are never altered
    p_payload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot.kind == SL_PAY) |=> (dout == $past(din)));

    // R4: a taken FEAC bit appears on the output one cycle later
    p_feac_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        feac_take |=> (dout == $past(feac_bit)));

    // R3: unused C-bit slots are driven high under frame generation
    p_cone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot.kind == SL_CONE) && frame_gen_en) |=> dout);

    // R4: the two take strobes are never high together
    p_take_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({feac_take, dl_take}));

endmodule

// File: tb/ds3_cbit_ohgen_tb.sv
module ds3_cbit_ohgen_tb;

    localparam int SUBFR = 7;
    localparam int BLKS  = 8;
    localparam int PAYB  = 84;
    localparam int NFR   = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0, sof_in = 1'b0;
    logic       frame_gen_en = 1'b0, pbit_gen_en = 1'b0, febe_auto = 1'b1, febe_val = 1'b0;
    logic [3:0] rai_en = 4'h0;
    logic       los = 1'b0, sef = 1'b0, lof = 1'b0, ais = 1'b0, cp_err = 1'b0;
    logic       feac_bit = 1'b0, dl_bit = 1'b0;
    logic       dout, dout_sof, feac_take, dl_take;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    logic  m_acc = 1'b0, m_par = 1'b0, m_err = 1'b0, m_ferr = 1'b0;
    logic  prev_exp = 1'b0, prev_sof = 1'b0;
    bit    have_prev = 1'b0;
    string prev_req = "R10";
    bit    cp_on = 1'b0;

    always #10 clk = ~clk;

    ds3_cbit_ohgen u_dut (
        .clk (clk), .rst_n (rst_n), .din (din), .sof_in (sof_in),
        .frame_gen_en (frame_gen_en), .pbit_gen_en (pbit_gen_en),
        .febe_auto (febe_auto), .febe_val (febe_val), .rai_en (rai_en),
        .los (los), .sef (sef), .lof (lof), .ais (ais), .cp_err (cp_err),
        .feac_bit (feac_bit), .dl_bit (dl_bit),
        .dout (dout), .dout_sof (dout_sof), .feac_take (feac_take), .dl_take (dl_take)
    );

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic rai_model();
        return !((rai_en[0] & los) | (rai_en[1] & sef) | (rai_en[2] & lof) | (rai_en[3] & ais));
    endfunction

    function automatic logic model_out(bit locked, int sf, int blk, int bt, logic d);
        if (!locked || bt != 0) return d;
        if (!frame_gen_en) begin
            if (pbit_gen_en && blk == 0 && (sf == 2 || sf == 3)) return m_par;
            return d;
        end
        if (blk == 0) begin
            if (sf < 2) return rai_model();
            if (sf < 4) return m_par;
            return (sf == 5);
        end
        if (blk % 2 == 1) return (blk == 1 || blk == 7);
        case (sf)
            0:       return (blk == 6) ? feac_bit : 1'b1;
            2:       return m_par;
            3:       return febe_auto ? !m_ferr : febe_val;
            4:       return dl_bit;
            default: return 1'b1;
        endcase
    endfunction

    function automatic string req_of(bit locked, int sf, int blk, int bt);
        if (!locked || bt != 0) return "R10";
        if (!frame_gen_en) return (pbit_gen_en && blk == 0 && (sf == 2 || sf == 3)) ? "R2" : "R9";
        if (blk == 0) return (sf < 2) ? "R7" : (sf < 4) ? "R1" : "R8";
        if (blk % 2 == 1) return "R8";
        case (sf)
            0:       return (blk == 6) ? "R4" : "R3";
            2:       return "R5";
            3:       return "R6";
            4:       return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic step(input bit locked, input int sf, input int blk, input int bt);
        logic d;
        @(negedge clk);
        if (have_prev) begin
            chk(prev_req, dout, prev_exp, "dout");
            chk("R10", dout_sof, prev_sof, "dout_sof");
        end
        d        = 1'($urandom % 2);
        din      = d;
        sof_in   = locked && sf == 0 && blk == 0 && bt == 0;
        feac_bit = 1'($urandom % 2);
        dl_bit   = 1'($urandom % 2);
        los      = ($urandom % 4) == 0;
        sef      = ($urandom % 4) == 0;
        lof      = ($urandom % 4) == 0;
        ais      = ($urandom % 4) == 0;
        cp_err   = locked && cp_on && (($urandom % 500) == 0);
        #1;
        chk("R4", feac_take, locked && frame_gen_en && sf == 0 && blk == 6 && bt == 0, "feac_take");
        chk("R4", dl_take, locked && frame_gen_en && sf == 4 && bt == 0 && blk != 0 && blk % 2 == 0,
            "dl_take");
        prev_exp  = model_out(locked, sf, blk, bt, d);
        prev_req  = req_of(locked, sf, blk, bt);
        prev_sof  = sof_in;
        have_prev = 1'b1;
        if (locked) begin
            if (bt != 0) m_acc = m_acc ^ d;
            m_err = m_err | cp_err;
            if (sf == SUBFR - 1 && blk == BLKS - 1 && bt == PAYB) begin
                m_par  = m_acc;
                m_ferr = m_err;
                m_acc  = 1'b0;
                m_err  = 1'b0;
            end
        end
    endtask

    task automatic set_frame_cfg(input int fr);
        case (fr)
            0: begin frame_gen_en = 1; pbit_gen_en = 0; febe_auto = 1; rai_en = 4'hF; cp_on = 0; end
            1: begin frame_gen_en = 1; pbit_gen_en = 0; febe_auto = 0; febe_val = 0; cp_on = 1;
                     rai_en = 4'b0101; end
            2: begin frame_gen_en = 0; pbit_gen_en = 1; cp_on = 0; end
            3: begin frame_gen_en = 0; pbit_gen_en = 0; cp_on = 1; end
            4: begin frame_gen_en = 1; pbit_gen_en = 1; febe_auto = 1; rai_en = 4'h0; cp_on = 0; end
            5: begin frame_gen_en = 1; pbit_gen_en = 0; febe_auto = 1; cp_on = 1;
                     rai_en = 4'($urandom % 16); end
            default: begin frame_gen_en = 1; febe_auto = 1; febe_val = 1'($urandom % 2);
                     pbit_gen_en = 1'($urandom % 2); rai_en = 4'($urandom % 16); cp_on = 1; end
        endcase
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state of the outputs
        chk("R11", dout, 1'b0, "reset dout");
        chk("R11", dout_sof, 1'b0, "reset dout_sof");
        frame_gen_en = 1'b1;
        // R10: unaligned bits pass through
        for (int i = 0; i < 20; i++) step(1'b0, 0, 0, 0);
        for (int fr = 0; fr < NFR; fr++) begin
            set_frame_cfg(fr);
            for (int sf = 0; sf < SUBFR; sf++)
                for (int blk = 0; blk < BLKS; blk++)
                    for (int bt = 0; bt <= PAYB; bt++)
                        step(1'b1, sf, blk, bt);
        end
        @(negedge clk);
        chk(prev_req, dout, prev_exp, "dout");
        chk("R10", dout_sof, prev_sof, "dout_sof");
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule